// File: doc/BRIEF.md
# Ripple-Timed Chain Node Numbering

Identical processing nodes wired in a line leave a common reset with no idea of where they sit. This block gives each node its position number without straps or a central arbiter. Each node watches one input coming from its upstream neighbour and drives one output to its downstream neighbour. The input of the head node is tied high. Every output is low after reset, so a single high level ripples down the line, one node at a time.

A node counts clock edges from reset release until the synchronised input reads high. It turns that count into a position number by rounded division by `STAGE_CYCLES`. It then waits so that its own input-to-output delay is exactly `STAGE_CYCLES` clocks, and raises its output together with a valid flag for the local application. The application starts once the flag is high. If the input never rises within `TIMEOUT_CYCLES`, the node flags an error and never releases its output.

Top module: `chain_enum_node`

## Requirements
- R1: While `rst_ni` is low, `chain_o`, `id_valid_o` and `err_o` are 0 and `id_o` is 0.
- R2: Edges are numbered from 1, where edge 1 is the first rising clock edge after `rst_ni` goes high. Let j be the first such edge at which `chain_i` is sampled high. The elapsed count is then j+1, because the two-flop synchroniser adds its delay and the count stops on the first synchronised high.
- R3: `id_o` equals floor((count + STAGE_CYCLES/2) / STAGE_CYCLES), saturated at 2^ID_W-1. With the defaults (STAGE_CYCLES=16) the head node, with j=1, gets ID 0.
- R4: `chain_o` and `id_valid_o` both rise just after edge j+STAGE_CYCLES-1 and not before. Each node in the line therefore adds exactly STAGE_CYCLES clocks to the ripple.
- R5: Once `id_valid_o` is high, it, `chain_o` and `id_o` hold their values until reset. Later changes on `chain_i` have no effect on them.
- R6: If `chain_i` is low at every edge from 1 to TIMEOUT_CYCLES-1, `err_o` rises just after edge TIMEOUT_CYCLES+1. In that case `chain_o` and `id_valid_o` stay 0.
- R7: After `err_o` rises, it stays high until reset. A later rise on `chain_i` leaves `chain_o` and `id_valid_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chain_i | input | 1 | Ripple level from the upstream node (tied high on the head node) |
| chain_o | output | 1 | Ripple level to the downstream node |
| id_o | output | ID_W | Position number |
| id_valid_o | output | 1 | Position number is final |
| err_o | output | 1 | Upstream ripple never arrived within the timeout |

## Verification
The assertions assume that `rst_ni` is held low long enough for the asynchronous reset to settle, and that `chain_i` is a level that rises at most once per enumeration. Only the ignore checks lower it again, and only after the node has already committed. The stimulus changes `chain_i` and `rst_ni` only on falling clock edges. It picks arrival edges on both sides of each rounding boundary and the last edge before the timeout, so every count the node captures stays within the default timeout and ID range.

// File: rtl/chain_enum_pkg.sv
package chain_enum_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_HOLD = 2'd1,
    ST_DONE = 2'd2,
    ST_FAIL = 2'd3
  } enum_state_e;
endpackage

// File: rtl/chain_sync.sv
module chain_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] sh_q;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sh_q[0] <= 1'b0;
          else         sh_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sh_q[g] <= 1'b0;
          else         sh_q[g] <= sh_q[g-1];
      end
    end
  endgenerate

  assign q_o = sh_q[DEPTH-1];
endmodule

// File: rtl/elapsed_timer.sv
module elapsed_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;

  assign cnt_o = cnt_q;
endmodule

// File: rtl/id_round.sv
module id_round #(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned ID_W         = 4,
  parameter int unsigned STAGE_CYCLES = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [ID_W-1:0]  id_o
);
  localparam int unsigned HALF   = STAGE_CYCLES / 2;
  localparam int unsigned ID_MAX = (1 << ID_W) - 1;

  logic [31:0] sum_w;
  logic [31:0] quo_w;

  assign sum_w = 32'(cnt_i) + HALF;
  assign quo_w = sum_w / STAGE_CYCLES;
  assign id_o  = (quo_w > ID_MAX) ? ID_W'(ID_MAX) : quo_w[ID_W-1:0];
endmodule

// File: rtl/chain_enum_node.sv
module chain_enum_node #(
  parameter int unsigned ID_W           = 4,
  parameter int unsigned STAGE_CYCLES   = 16,
  parameter int unsigned TIMEOUT_CYCLES = 240
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            chain_i,
  output logic            chain_o,
  output logic [ID_W-1:0] id_o,
  output logic            id_valid_o,
  output logic            err_o
);
  import chain_enum_pkg::*;

  localparam int unsigned SYNC_DEPTH  = 2;
  localparam int unsigned CNT_W       = $clog2(TIMEOUT_CYCLES + 1);
  // input-to-output delay = SYNC_DEPTH + 1 (capture) + HOLD_CYCLES
  localparam int unsigned HOLD_CYCLES = STAGE_CYCLES - SYNC_DEPTH - 1;
  localparam int unsigned HOLD_W      = $clog2(HOLD_CYCLES + 1);

  enum_state_e       state_q;
  logic [HOLD_W-1:0] hold_q;
  logic [ID_W-1:0]   id_q;
  logic              seen_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [ID_W-1:0]   id_rnd_w;

  chain_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (chain_i),
    .q_o   (seen_w)
  );

  elapsed_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q == ST_WAIT),
    .cnt_o (cnt_w)
  );

  id_round #(.CNT_W(CNT_W), .ID_W(ID_W), .STAGE_CYCLES(STAGE_CYCLES)) u_round (
    .cnt_i(cnt_w),
    .id_o (id_rnd_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      hold_q  <= '0;
      id_q    <= '0;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (seen_w) begin
            id_q    <= id_rnd_w;
            hold_q  <= '0;
            state_q <= ST_HOLD;
          end else if (cnt_w == CNT_W'(TIMEOUT_CYCLES)) begin
            state_q <= ST_FAIL;
          end
        end
        ST_HOLD: begin
          if (hold_q == HOLD_W'(HOLD_CYCLES - 1)) state_q <= ST_DONE;
          else                                    hold_q  <= hold_q + 1'b1;
        end
        default: state_q <= state_q;
      endcase
    end
  end

  assign chain_o    = (state_q == ST_DONE);
  assign id_valid_o = (state_q == ST_DONE);
  assign err_o      = (state_q == ST_FAIL);
  assign id_o       = id_q;
endmodule

// File: rtl/chain_enum_chk.sv
module chain_enum_chk #(
  parameter int unsigned ID_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            chain_i,
  input logic            chain_o,
  input logic [ID_W-1:0] id_o,
  input logic            id_valid_o,
  input logic            err_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!chain_o && !id_valid_o && !err_o && id_o == '0));

  // R5
  out_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_o |=> chain_o);

  // R5
  id_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_o |=> (id_valid_o && $stable(id_o)));

  // R6
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!chain_o && !id_valid_o));

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R4
  rise_needs_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chain_o) |-> !err_o);
endmodule

bind chain_enum_node chain_enum_chk #(.ID_W(ID_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chain_i   (chain_i),
  .chain_o   (chain_o),
  .id_o      (id_o),
  .id_valid_o(id_valid_o),
  .err_o     (err_o)
);

// File: tb/chain_enum_node_bench.sv
`timescale 1ns/1ps
module chain_enum_node_bench;
  localparam int ID_W    = 4;
  localparam int STAGE   = 16;
  localparam int TIMEOUT = 240;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chain_in = 1'b0;
  logic chain_out, valid, err;
  logic [ID_W-1:0] id;

  int cyc;
  int n_chk = 0;
  int n_fail = 0;
  logic valid_prev = 1'b0;
  bit done = 1'b0;

  typedef struct { int id; int edge_no; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  chain_enum_node #(.ID_W(ID_W), .STAGE_CYCLES(STAGE), .TIMEOUT_CYCLES(TIMEOUT)) u_chain_enum_node (
    .clk_i(clk), .rst_ni(rst_n), .chain_i(chain_in), .chain_o(chain_out),
    .id_o(id), .id_valid_o(valid), .err_o(err)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: compare each valid rise against the scoreboard
  always @(negedge clk) begin
    if (rst_n && valid && !valid_prev) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cyc == e.edge_no, "R2/R4 valid edge", cyc, e.edge_no);
        check(int'(id) == e.id, "R3 id value", int'(id), e.id);
        check(chain_out == 1'b1, "R4 chain_o with valid", int'(chain_out), 1);
      end
    end
    valid_prev = valid;
  end

  task automatic wait_edge(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic do_reset(input bit tie_high);
    @(negedge clk);
    rst_n = 1'b0;
    chain_in = tie_high;
    repeat (2) @(negedge clk);
    // R1
    check(!chain_out && !valid && !err && id == '0, "R1 reset state",
          {chain_out, valid, err}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_case(input int j);
    exp_t e;
    do_reset(j == 1);
    if (j > 1) begin
      wait_edge(j - 1);
      chain_in = 1'b1;
    end
    e.id = (j + 1 + STAGE / 2) / STAGE;
    e.edge_no = j + STAGE - 1;
    exp_q.push_back(e);
    wait_edge(j + STAGE - 2);
    // R4: not early
    check(!chain_out && !valid, "R4 early release", {chain_out, valid}, 0);
    wait_edge(j + STAGE + 2);
    check(exp_q.size() == 0, "R4 valid missing", exp_q.size(), 0);
  endtask

  initial begin
    run_case(1);    // head node: id 0
    run_case(17);   // id 1
    run_case(22);   // count 23 -> 1
    run_case(23);   // count 24 -> 2 (boundary)
    run_case(100);  // id 6
    run_case(TIMEOUT - 1); // last edge before timeout: id 15

    // R5: drop input after commit
    run_case(40);
    chain_in = 1'b0;
    repeat (20) @(negedge clk);
    check(chain_out && valid, "R5 outputs held", {chain_out, valid}, 3);
    check(int'(id) == 3, "R5 id held", int'(id), 3);

    // R6: timeout
    do_reset(1'b0);
    wait_edge(TIMEOUT - 1);
    chain_in = 1'b1;
    wait_edge(TIMEOUT);
    check(!err, "R6 err not early", int'(err), 0);
    wait_edge(TIMEOUT + 1);
    check(err, "R6 err raised", int'(err), 1);
    check(!chain_out && !valid, "R6 no release", {chain_out, valid}, 0);
    // R7: input high after error ignored
    repeat (40) @(negedge clk);
    check(err && !chain_out && !valid, "R7 error sticky",
          {err, chain_out, valid}, 4);

    finish_run();
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end
endmodule